// File: doc/BRIEF.md
# UART Transmit Framer

This block turns one character at a time into an asynchronous serial frame on a single output line. A line-control word chooses the frame shape: character length of five to eight bits, one or more stop bits, an optional parity bit of one of four kinds, and a break override that pulls the line low. A separate nine-bit enable sets the character length to nine bits and removes the parity bit, whatever the length and parity fields hold.

Characters arrive on a valid/ready handshake. The framer takes a character only when the line is idle, and it latches the frame format at that moment. Bit timing comes from an external tick that runs at sixteen times the bit rate. Each bit lasts sixteen ticks, and a half stop bit lasts eight. Only the break bit acts on the line at once. The format fields apply to the next accepted character.

Top module: `uart_tx_framer`

## Requirements
- R1: During reset and just after it, `txd` is high and `tx_idle` and `char_ready` are both 1. A reset during a frame drops the frame and leaves the line high.
- R2: A frame is a low start bit, then the data bits least significant first, then the optional parity bit, then high stop bits. Every bit except a stop bit lasts 16 ticks, and the start bit is on the line in the cycle after acceptance.
- R3: Control bits [1:0] give the character length: 00 gives 5, 01 gives 6, 10 gives 7 and 11 gives 8 data bits.
- R4: With control bit [2] = 0 there is one stop bit of 16 ticks. With bit [2] = 1 the stop time is 24 ticks for 5-bit characters and 32 ticks for any longer character.
- R5: Control bit [3] = 0 sends no parity bit. With bit [3] = 1, bits [5:4] choose the parity: 00 odd (the data bits plus parity hold an odd number of ones), 01 even, 10 a parity bit that is always 1, 11 a parity bit that is always 0.
- R6: Control bit [6] = 1 drives `txd` low in the same cycle, whether the line is idle or a frame is under way. The frame keeps its timing, so the line shows the frame level again when the bit clears.
- R7: With `nine_bit_en` = 1 the frame carries all 9 data bits and no parity bit, and control bits [1:0] and [5:3] are ignored. Bit [2] then works as for an 8-bit character.
- R8: `char_ready` is 1 only while idle, and a character is taken on a cycle with `char_valid` and `char_ready` both 1. Changing control bits [5:0], `nine_bit_en` or `char_data` after acceptance has no effect on the frame in progress.
- R9: `tx_idle` and `char_ready` return to 1 in the cycle after the tick that ends the last stop bit, with the line high.
- R10: Bit time advances only on `tick`. With no tick the line holds its level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tick | input | 1 | One-cycle pulse at 16 times the bit rate |
| ctrl_word | input | 7 | Line control: [1:0] length, [2] stop, [5:3] parity, [6] break |
| nine_bit_en | input | 1 | Nine-bit framing mode |
| char_data | input | 9 | Character to send (bit 8 used only in nine-bit mode) |
| char_valid | input | 1 | Character offered |
| char_ready | output | 1 | Framer can take a character |
| txd | output | 1 | Serial output line |
| tx_idle | output | 1 | No frame in progress |

## Verification
The hardest case to reach is a format change arriving while a frame is on the line. This is where latching the format at acceptance has to show. The bench changes the length, parity and nine-bit inputs right after a character is taken, and keeps `char_valid` high with new data during a frame. It then compares the line tick by tick against the first format. Break is raised partway through a data bit and dropped later, to confirm the frame timing ran on underneath. A long run with no ticks during the start bit shows that nothing moves without `tick`.

// File: rtl/uart_tx_pkg.sv
package uart_tx_pkg;

   localparam int unsigned MAX_DATA_BITS = 9;
   localparam int unsigned CTRL_BITS     = 7;
   localparam int unsigned NB_W          = $clog2(MAX_DATA_BITS + 1);

   typedef enum logic [2:0] {
      ST_IDLE  = 3'd0,
      ST_START = 3'd1,
      ST_DATA  = 3'd2,
      ST_PAR   = 3'd3,
      ST_STOP  = 3'd4
   } tx_state_e;

   typedef enum logic [1:0] {
      PAR_ODD   = 2'd0,
      PAR_EVEN  = 2'd1,
      PAR_MARK  = 2'd2,
      PAR_SPACE = 2'd3
   } par_kind_e;

   typedef struct packed {
      logic [NB_W-1:0] nbits;
      logic            par_en;
      par_kind_e       par_kind;
      logic [2:0]      stop_halves;
   } frame_fmt_t;

endpackage

// File: rtl/uart_tx_fmt_dec.sv
module uart_tx_fmt_dec
   import uart_tx_pkg::*;
(
   input  logic [5:0] fields,
   input  logic       nine_bit,
   output frame_fmt_t fmt
);

   localparam logic [NB_W-1:0] MIN_LEN = NB_W'(5);
   localparam logic [NB_W-1:0] NINE    = NB_W'(MAX_DATA_BITS);

   always_comb begin
      fmt.nbits    = nine_bit ? NINE : MIN_LEN + NB_W'(fields[1:0]);
      fmt.par_en   = !nine_bit && fields[3];
      fmt.par_kind = par_kind_e'(fields[5:4]);
      if (!fields[2])
         fmt.stop_halves = 3'd2;
      else if (fmt.nbits == MIN_LEN)
         fmt.stop_halves = 3'd3;
      else
         fmt.stop_halves = 3'd4;
   end

endmodule

// File: rtl/uart_tx_parity.sv
module uart_tx_parity
   import uart_tx_pkg::*;
(
   input  logic [MAX_DATA_BITS-1:0] data,
   input  frame_fmt_t               fmt,
   output logic                     pbit
);

   logic [MAX_DATA_BITS-1:0] keep;
   logic                     ones_odd;

   for (genvar gi = 0; gi < MAX_DATA_BITS; gi++) begin : g_mask
      assign keep[gi] = (fmt.nbits > NB_W'(gi));
   end

   assign ones_odd = ^(data & keep);

   always_comb begin
      case (fmt.par_kind)
         PAR_ODD:  pbit = ~ones_odd;
         PAR_EVEN: pbit = ones_odd;
         PAR_MARK: pbit = 1'b1;
         default:  pbit = 1'b0;
      endcase
   end

endmodule

// File: rtl/uart_tx_bit_timer.sv
module uart_tx_bit_timer #(
   parameter int unsigned OVERSAMPLE = 16
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       tick,
   input  logic       restart,
   input  logic       in_stop,
   input  logic [2:0] stop_halves,
   output logic       bit_done
);

   localparam int unsigned HALF  = OVERSAMPLE / 2;
   localparam int unsigned CNT_W = $clog2(2 * OVERSAMPLE) + 1;

   if (OVERSAMPLE < 4 || (OVERSAMPLE % 2) != 0) begin : g_bad_ovs
      $error("OVERSAMPLE must be even and at least 4");
   end

   logic [CNT_W-1:0] cnt;
   logic [CNT_W-1:0] limit;

   assign limit    = in_stop ? CNT_W'(stop_halves) * CNT_W'(HALF) : CNT_W'(OVERSAMPLE);
   assign bit_done = tick && (cnt == limit - CNT_W'(1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt <= '0;
      else if (restart || bit_done)
         cnt <= '0;
      else if (tick)
         cnt <= cnt + CNT_W'(1);
   end

endmodule

// File: rtl/uart_tx_seq.sv
module uart_tx_seq
   import uart_tx_pkg::*;
(
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     accept,
   input  logic [MAX_DATA_BITS-1:0] data_in,
   input  frame_fmt_t               fmt_in,
   input  logic                     pbit_in,
   input  logic                     bit_done,
   output logic                     line,
   output logic                     in_stop,
   output logic [2:0]               stop_halves,
   output logic                     idle
);

   tx_state_e                state;
   logic [MAX_DATA_BITS-1:0] shreg;
   logic [NB_W-1:0]          idx;
   frame_fmt_t               fmt_q;
   logic                     pbit_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state  <= ST_IDLE;
         shreg  <= '0;
         idx    <= '0;
         fmt_q  <= '0;
         pbit_q <= 1'b0;
      end else if (accept) begin
         state  <= ST_START;
         shreg  <= data_in;
         idx    <= '0;
         fmt_q  <= fmt_in;
         pbit_q <= pbit_in;
      end else if (bit_done) begin
         case (state)
            ST_START: state <= ST_DATA;
            ST_DATA: begin
               shreg <= shreg >> 1;
               idx   <= idx + NB_W'(1);
               if (idx == fmt_q.nbits - NB_W'(1))
                  state <= fmt_q.par_en ? ST_PAR : ST_STOP;
            end
            ST_PAR:  state <= ST_STOP;
            default: state <= ST_IDLE;
         endcase
      end
   end

   always_comb begin
      case (state)
         ST_START: line = 1'b0;
         ST_DATA:  line = shreg[0];
         ST_PAR:   line = pbit_q;
         default:  line = 1'b1;
      endcase
   end

   assign in_stop     = (state == ST_STOP);
   assign stop_halves = fmt_q.stop_halves;
   assign idle        = (state == ST_IDLE);

endmodule

// File: rtl/uart_tx_framer.sv
module uart_tx_framer
   import uart_tx_pkg::*;
#(
   parameter int unsigned OVERSAMPLE = 16
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       tick,
   input  logic [6:0] ctrl_word,
   input  logic       nine_bit_en,
   input  logic [8:0] char_data,
   input  logic       char_valid,
   output logic       char_ready,
   output logic       txd,
   output logic       tx_idle
);

   localparam int unsigned BRK_BIT = CTRL_BITS - 1;

   frame_fmt_t fmt_now;
   logic       pbit_now;
   logic       accept;
   logic       bit_done;
   logic       frame_line;
   logic       in_stop;
   logic [2:0] stop_halves;
   logic       seq_idle;

   assign accept = char_valid && seq_idle;

   uart_tx_fmt_dec u_fmt (
      .fields   (ctrl_word[5:0]),
      .nine_bit (nine_bit_en),
      .fmt      (fmt_now)
   );

   uart_tx_parity u_par (
      .data (char_data),
      .fmt  (fmt_now),
      .pbit (pbit_now)
   );

   uart_tx_bit_timer #(.OVERSAMPLE(OVERSAMPLE)) u_timer (
      .clk         (clk),
      .rst_n       (rst_n),
      .tick        (tick),
      .restart     (accept),
      .in_stop     (in_stop),
      .stop_halves (stop_halves),
      .bit_done    (bit_done)
   );

   uart_tx_seq u_seq (
      .clk         (clk),
      .rst_n       (rst_n),
      .accept      (accept),
      .data_in     (char_data),
      .fmt_in      (fmt_now),
      .pbit_in     (pbit_now),
      .bit_done    (bit_done),
      .line        (frame_line),
      .in_stop     (in_stop),
      .stop_halves (stop_halves),
      .idle        (seq_idle)
   );

   assign char_ready = seq_idle;
   assign tx_idle    = seq_idle;
   assign txd        = ctrl_word[BRK_BIT] ? 1'b0 : frame_line;

endmodule

// File: rtl/uart_tx_framer_chk.sv
module uart_tx_framer_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       tick,
   input logic [6:0] ctrl_word,
   input logic       char_valid,
   input logic       char_ready,
   input logic       txd,
   input logic       tx_idle
);

   logic took;
   assign took = char_valid && char_ready;

   assert_start_low_R2: assert property (@(posedge clk) disable iff (!rst_n)
      took |=> !txd);

   assert_break_low_R6: assert property (@(posedge clk) disable iff (!rst_n)
      ctrl_word[6] |-> !txd);

   assert_taken_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
      took |=> !tx_idle);

   assert_idle_high_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_idle && !ctrl_word[6]) |-> txd);

   assert_no_tick_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (!tick && !took && !ctrl_word[6]) |=> (ctrl_word[6] || $stable(txd)));

endmodule

bind uart_tx_framer uart_tx_framer_chk u_chk (.*);

// File: tb/uart_tx_framer_tb_top.sv
module uart_tx_framer_tb_top;

   localparam int OVS  = 16;
   localparam int TDIV = 3;
   localparam int NVEC = 12;

   // {ctrl[6:0], nine_bit, data[8:0], expected frame length in ticks}
   localparam logic [25:0] VECS [NVEC] = '{
      {7'b0000011, 1'b0, 9'h0A5, 9'd160},
      {7'b0000000, 1'b0, 9'h0D6, 9'd112},
      {7'b0001001, 1'b0, 9'h02B, 9'd144},
      {7'b0011010, 1'b0, 9'h055, 9'd160},
      {7'b0101011, 1'b0, 9'h000, 9'd176},
      {7'b0111011, 1'b0, 9'h0FF, 9'd176},
      {7'b0000100, 1'b0, 9'h013, 9'd120},
      {7'b0001101, 1'b0, 9'h03C, 9'd160},
      {7'b0001100, 1'b1, 9'h1A5, 9'd192},
      {7'b0111001, 1'b1, 9'h0F0, 9'd176},
      {7'b0110011, 1'b0, 9'h081, 9'd160},
      {7'b0011111, 1'b0, 9'h001, 9'd192}
   };

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       tick = 1'b0;
   logic [6:0] ctrl_word = '0;
   logic       nine_bit_en = 1'b0;
   logic [8:0] char_data = '0;
   logic       char_valid = 1'b0;
   logic       char_ready;
   logic       txd;
   logic       tx_idle;

   int checks = 0;
   int fails  = 0;

   always #10 clk = ~clk;

   uart_tx_framer #(.OVERSAMPLE(OVS)) dut_i (
      .clk         (clk),
      .rst_n       (rst_n),
      .tick        (tick),
      .ctrl_word   (ctrl_word),
      .nine_bit_en (nine_bit_en),
      .char_data   (char_data),
      .char_valid  (char_valid),
      .char_ready  (char_ready),
      .txd         (txd),
      .tx_idle     (tx_idle)
   );

   task automatic check(input bit ok, input string req, input string what,
                        input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   function automatic logic exp_level(input logic [6:0] c, input logic nb,
                                      input logic [8:0] d, input int j);
      int   b, n;
      logic p, x, par;
      b = j / OVS;
      n = nb ? 9 : 5 + int'(c[1:0]);
      p = !nb && c[3];
      x = 1'b0;
      for (int i = 0; i < n; i++) x ^= d[i];
      case (c[5:4])
         2'b00:   par = ~x;
         2'b01:   par = x;
         2'b10:   par = 1'b1;
         default: par = 1'b0;
      endcase
      if (b == 0) return 1'b0;
      if (b <= n) return d[b-1];
      if (p && b == n + 1) return par;
      return 1'b1;
   endfunction

   task automatic run_frame(input logic [6:0] c, input logic nb, input logic [8:0] d,
                            input int total, input int brk_lo, input int brk_hi,
                            input bit mid_change, input bit hold_valid, input string req);
      int   errs, j, ph, at_j;
      logic expv, f_act, f_exp;
      bit   in_brk;
      errs = 0; j = 0; ph = 0; at_j = 0; f_act = 1'b0; f_exp = 1'b0;
      @(negedge clk);
      tick = 1'b0; ctrl_word = c; nine_bit_en = nb; char_data = d; char_valid = 1'b1;
      @(negedge clk);
      if (hold_valid) char_data = ~d;
      else char_valid = 1'b0;
      if (mid_change) begin
         ctrl_word[5:0] = ~c[5:0];
         nine_bit_en = ~nb;
      end
      while (j < total) begin
         in_brk = (j >= brk_lo) && (j < brk_hi);
         tick = (ph == 0);
         ph = (ph + 1) % TDIV;
         ctrl_word[6] = c[6] | in_brk;
         #1;
         expv = in_brk ? 1'b0 : exp_level(c, nb, d, j);
         if (txd !== expv || tx_idle !== 1'b0 || char_ready !== 1'b0) begin
            if (errs == 0) begin
               f_act = txd; f_exp = expv; at_j = j;
            end
            errs++;
         end
         if (tick) j++;
         @(negedge clk);
      end
      tick = 1'b0; char_valid = 1'b0; ctrl_word[6] = 1'b0;
      #1;
      check(errs == 0, req, $sformatf("frame line at tick %0d", at_j),
            int'(f_act), int'(f_exp));
      check(txd === 1'b1 && tx_idle === 1'b1 && char_ready === 1'b1, "R9",
            "idle and ready right after last stop tick",
            int'({txd, tx_idle, char_ready}), 7);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      check(1'b0, "ALL", "watchdog expired", 0, 1);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

   initial begin
      logic [25:0] v;
      int          errs;
      int          guard;

      // R1: reset state
      repeat (3) @(negedge clk);
      #1;
      check(txd === 1'b1 && tx_idle === 1'b1 && char_ready === 1'b1, "R1",
            "line high, idle, ready during reset", int'({txd, tx_idle, char_ready}), 7);
      rst_n = 1'b1;
      @(negedge clk);
      #1;
      check(txd === 1'b1 && tx_idle === 1'b1 && char_ready === 1'b1, "R1",
            "line high, idle, ready after reset", int'({txd, tx_idle, char_ready}), 7);

      // R2 R3 R4 R5 R7: table walk
      for (int k = 0; k < NVEC; k++) begin
         v = VECS[k];
         run_frame(v[25:19], v[18], v[17:9], int'(v[8:0]), 0, 0, 1'b0, 1'b0,
                   (k == 6 || k == 7 || k == 11) ? "R4" :
                   (k >= 2 && k <= 5) || k == 10 ? "R5" :
                   (k == 8 || k == 9) ? "R7" : "R3");
      end

      // R8: format inputs flipped right after acceptance
      v = VECS[3];
      run_frame(v[25:19], v[18], v[17:9], int'(v[8:0]), 0, 0, 1'b1, 1'b0, "R8");
      v = VECS[8];
      run_frame(v[25:19], v[18], v[17:9], int'(v[8:0]), 0, 0, 1'b1, 1'b0, "R8");
      // R8: valid held high with other data during the frame
      v = VECS[2];
      run_frame(v[25:19], v[18], v[17:9], int'(v[8:0]), 0, 0, 1'b0, 1'b1, "R8");

      // R6: break raised mid-data-bit, then released
      v = VECS[0];
      run_frame(v[25:19], v[18], v[17:9], int'(v[8:0]), 37, 71, 1'b0, 1'b0, "R6");

      // R6: break while idle
      @(negedge clk);
      ctrl_word = 7'b1000011;
      #1;
      check(txd === 1'b0 && char_ready === 1'b1, "R6", "break while idle",
            int'({txd, char_ready}), 1);
      @(negedge clk);
      ctrl_word = 7'b0000011;
      #1;
      check(txd === 1'b1, "R6", "line high after break released", int'(txd), 1);

      // R10: no ticks for a long stretch during the start bit
      @(negedge clk);
      char_data = 9'h1FF; char_valid = 1'b1; tick = 1'b0;
      @(negedge clk);
      char_valid = 1'b0;
      errs = 0;
      repeat (60) begin
         #1;
         if (txd !== 1'b0) errs++;
         @(negedge clk);
      end
      check(errs == 0, "R10", "start bit held without ticks", errs, 0);
      guard = 0;
      while (tx_idle !== 1'b1 && guard < 2000) begin
         tick = ~tick;
         guard++;
         @(negedge clk);
      end
      tick = 1'b0;
      check(guard == 2 * 160 - 1, "R10", "frame length counted in ticks only", guard, 2 * 160 - 1);

      // R1: reset in the middle of a frame
      @(negedge clk);
      ctrl_word = 7'b0000011; char_data = 9'h000; char_valid = 1'b1;
      @(negedge clk);
      char_valid = 1'b0;
      repeat (40) begin
         tick = ~tick;
         @(negedge clk);
      end
      tick = 1'b0;
      #1;
      check(txd === 1'b0, "R2", "data zero on line before reset", int'(txd), 0);
      rst_n = 1'b0;
      #1;
      check(txd === 1'b1 && tx_idle === 1'b1 && char_ready === 1'b1, "R1",
            "reset mid-frame returns to idle", int'({txd, tx_idle, char_ready}), 7);
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

endmodule